// File: doc/BRIEF.md
# Power-Up Sequencer for a Converter Digital Path

This block brings the digital side of an audio converter out of power-up in a fixed order. It watches an asynchronous supply-good level, which it synchronizes into the system-clock domain before any counting. While supply-good is low, and for a fixed count of system-clock cycles after it rises, the block holds the internal logic in reset. After that, reset is released, but the audio output stays forced to zero until a second count has passed. This second count is measured in sample periods. It advances only on a per-sample strobe, so it follows the real sample rate rather than the clock.

When both counts are complete, the force-zero flag drops and the output-valid flag rises. If supply-good falls at any point, the block returns to reset and clears both counts. The full sequence then runs again from the start. All three outputs come from registers. The supply comparator that produces supply-good lies outside the block.

Top module: `power_up_sequencer`

## Requirements
- R1: With supply-good held low, the outputs settle to reset state (core reset 1, force-zero 1, valid 0) within SYNC_STAGES+1 rising clock edges and remain there.
- R2: Supply-good passes through SYNC_STAGES flops. Core reset falls on exactly the (HOLD_CYCLES+SYNC_STAGES)-th rising edge, counting the first edge that samples supply-good high as edge 1. The default HOLD_CYCLES is 1024.
- R3: Whenever core reset is high, force-zero is high and valid is low.
- R4: After reset release, force-zero stays high and valid stays low until the SETTLE_SAMPLES-th rising edge that samples the strobe high. Only edges after the release edge count. On that edge, force-zero falls and valid rises. The default SETTLE_SAMPLES is 18436.
- R5: Strobes sampled on or before the release edge are not counted. A pause in strobes during settling freezes the settle count without losing progress.
- R6: Once valid is high, further strobes have no effect, and the outputs hold until supply-good drops.
- R7: If supply-good is sampled low in any phase, the outputs return to reset state on the (SYNC_STAGES+1)-th edge. The next rise then needs the full hold count and the full settle count again.
- R8: Valid and force-zero are never equal once the outputs have settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock; every register samples on its rising edge |
| supply_ok_i | input | 1 | Asynchronous supply-good level, high when the supply is above threshold |
| sample_stb_i | input | 1 | One-cycle strobe, high once per sample period |
| core_rst_o | output | 1 | Active-high synchronous reset for the converter's internal logic |
| force_zero_o | output | 1 | High while the audio output must be driven as zero |
| out_valid_o | output | 1 | High once the output data may be used |

## Verification
The main sequence runs from supply rise to valid with strobes at one sample every two clocks, and again at one every three clocks. This shows that the settle count follows strobes rather than clocks. Supply-good is dropped in each of the three phases: during hold, during settle and while valid. Each drop tests that both counts restart and are not resumed. Strobes run throughout the hold phase and are paused for a while during settling. This separates a counter that wrongly counts strobes during reset from one that loses progress across a gap. The release edge is also measured from the supply rise on its own, so an off-by-one in the synchronizer or the hold count shows up.

// File: rtl/pus_pkg.sv
package pus_pkg;

  typedef enum logic [1:0] {
    PH_HOLD   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_LIVE   = 2'd2
  } phase_e;

  typedef struct packed {
    logic core_rst;
    logic force_zero;
    logic out_valid;
  } flags_t;

  // Output flags that belong to each phase.
  function automatic flags_t flags_for(phase_e p);
    flags_t f;
    case (p)
      PH_SETTLE: f = '{core_rst: 1'b0, force_zero: 1'b1, out_valid: 1'b0};
      PH_LIVE:   f = '{core_rst: 1'b0, force_zero: 1'b0, out_valid: 1'b1};
      default:   f = '{core_rst: 1'b1, force_zero: 1'b1, out_valid: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pus_sync.sv
// Multi-flop synchronizer that brings the asynchronous supply level into clk.
module pus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= async_i;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pus_span_counter.sv
// Counts advance pulses and flags the one that completes LIMIT of them.
module pus_span_counter #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] FINAL = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)      cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  assign last = adv && (cnt == FINAL);
endmodule

// File: rtl/pus_phase_fsm.sv
// Phase register with registered output flags derived from the next phase.
module pus_phase_fsm
  import pus_pkg::*;
(
  input  logic   clk,
  input  logic   supply_ok,
  input  logic   hold_last,
  input  logic   settle_last,
  output phase_e phase_o,
  output flags_t flags_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!supply_ok) begin
      phase_d = PH_HOLD;
    end else begin
      case (phase_q)
        PH_HOLD:   if (hold_last)   phase_d = PH_SETTLE;
        PH_SETTLE: if (settle_last) phase_d = PH_LIVE;
        PH_LIVE:   phase_d = PH_LIVE;
        default:   phase_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
    flags_o <= flags_for(phase_d);
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/power_up_sequencer.sv
module power_up_sequencer
  import pus_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int HOLD_CYCLES    = 1024,
  parameter int SETTLE_SAMPLES = 18436
) (
  input  logic clk_sys,
  input  logic supply_ok_i,
  input  logic sample_stb_i,
  output logic core_rst_o,
  output logic force_zero_o,
  output logic out_valid_o
);
  logic   pg_ok;
  phase_e phase;
  flags_t flags;
  logic   hold_adv, hold_clr, hold_last;
  logic   settle_adv, settle_clr, settle_last;

  pus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_sys),
    .async_i (supply_ok_i),
    .sync_o  (pg_ok)
  );

  // Hold count: system clock cycles spent in the hold phase.
  assign hold_adv = pg_ok && (phase == PH_HOLD);
  assign hold_clr = !pg_ok || (phase != PH_HOLD);

  pus_span_counter #(.LIMIT(HOLD_CYCLES)) u_hold_cnt (
    .clk  (clk_sys),
    .clr  (hold_clr),
    .adv  (hold_adv),
    .last (hold_last)
  );

  // Settle count: sample strobes seen after reset release.
  assign settle_adv = pg_ok && (phase == PH_SETTLE) && sample_stb_i;
  assign settle_clr = !pg_ok || (phase != PH_SETTLE);

  pus_span_counter #(.LIMIT(SETTLE_SAMPLES)) u_settle_cnt (
    .clk  (clk_sys),
    .clr  (settle_clr),
    .adv  (settle_adv),
    .last (settle_last)
  );

  pus_phase_fsm u_fsm (
    .clk         (clk_sys),
    .supply_ok   (pg_ok),
    .hold_last   (hold_last),
    .settle_last (settle_last),
    .phase_o     (phase),
    .flags_o     (flags)
  );

  assign core_rst_o   = flags.core_rst;
  assign force_zero_o = flags.force_zero;
  assign out_valid_o  = flags.out_valid;
endmodule

// File: rtl/pus_checker.sv
module pus_checker (
  input logic clk,
  input logic ok,
  input logic stb,
  input logic rst_o,
  input logic zero_o,
  input logic valid_o
);
  // Armed once the synchronized supply level has been seen low.
  logic armed;
  always_ff @(posedge clk) armed <= (ok === 1'b0) ? 1'b1 : armed;

  assert_reset_zero_R3: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    rst_o |-> (zero_o && !valid_o));

  assert_drop_restart_R7: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    !ok |=> (rst_o && zero_o && !valid_o));

  assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    $fell(rst_o) |-> $past(ok));

  assert_valid_on_strobe_R4: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    $rose(valid_o) |-> ($past(stb) && !$past(rst_o)));

  assert_live_hold_R6: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (valid_o && ok) |=> valid_o);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    valid_o != zero_o);
endmodule

bind power_up_sequencer pus_checker u_chk (
  .clk     (clk_sys),
  .ok      (pg_ok),
  .stb     (sample_stb_i),
  .rst_o   (core_rst_o),
  .zero_o  (force_zero_o),
  .valid_o (out_valid_o)
);

// File: tb/sim_power_up_sequencer.sv
module sim_power_up_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int HOLD       = 1024;
  localparam int SETTLE     = 18436;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic sup = 1'b0;
  logic stb = 1'b0;
  logic core_rst, force_zero, out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  power_up_sequencer #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .SETTLE_SAMPLES(SETTLE)) u0 (
    .clk_sys      (clk),
    .supply_ok_i  (sup),
    .sample_stb_i (stb),
    .core_rst_o   (core_rst),
    .force_zero_o (force_zero),
    .out_valid_o  (out_valid)
  );

  typedef struct packed { int cyc; logic [2:0] vec; } ev_t;
  ev_t q[$];

  int cyc = 0;
  int vectors = 0;
  int errs = 0;
  bit done = 0;

  // Strobe driver: high on every edge whose number is a multiple of stb_div.
  bit stb_en = 1'b1;
  int stb_div = 2;
  always @(negedge clk) stb <= stb_en && (((cyc + 1) % stb_div) == 0);

  // Expected behaviour from the requirements; pushes expected output changes.
  logic [SYNC-1:0] pipe = '0;
  int mph = 0;      // 0 hold, 1 settle, 2 live
  int hc = 0;
  int sc = 0;
  logic [2:0] mexp = 3'b110;   // {core_rst, force_zero, valid}
  always @(posedge clk) begin
    logic okp;
    logic [2:0] nv;
    cyc++;
    okp = pipe[SYNC-1];
    if (!okp) begin
      mph = 0; hc = 0; sc = 0;
    end else if (mph == 0) begin
      hc++;
      if (hc == HOLD) mph = 1;
    end else if (mph == 1) begin
      if (stb) begin
        sc++;
        if (sc == SETTLE) mph = 2;
      end
    end
    pipe = {pipe[SYNC-2:0], sup};
    nv = (mph == 0) ? 3'b110 : (mph == 1) ? 3'b010 : 3'b001;
    if (nv != mexp) begin
      mexp = nv;
      q.push_back('{cyc: cyc, vec: nv});
    end
  end

  function automatic string tag_of(logic [2:0] v);
    if (v == 3'b110) return "R7";
    if (v == 3'b010) return "R2";
    return "R4";
  endfunction

  task automatic chk_vec(string req, logic [2:0] act, logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: outputs=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: value=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the expected change whenever the outputs move.
  bit mon_on = 1'b0;
  logic [2:0] seen;
  int rel_cyc = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] now;
      ev_t ev;
      now = {core_rst, force_zero, out_valid};
      if (now !== seen) begin
        if (q.size() == 0) begin
          vectors++; errs++;
          $display("FAIL R7: unexpected change %b->%b at cycle %0d expected no change", seen, now, cyc);
        end else begin
          ev = q.pop_front();
          chk_vec(tag_of(ev.vec), now, ev.vec);
          chk_int(tag_of(ev.vec), cyc, ev.cyc);
        end
        if (now == 3'b010 && seen == 3'b110) rel_cyc = cyc;
        seen = now;
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        ev = q.pop_front();
        chk_vec(tag_of(ev.vec), now, ev.vec);
      end
    end
  end

  task automatic wait_phase(int ph);
    do @(negedge clk); while (!(mph == ph && q.size() == 0));
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  initial begin
    int rise_edge;
    sup = 1'b0;
    stb_en = 1'b1;
    stb_div = 2;
    repeat (5) @(negedge clk);
    // R1: reset state with supply low
    chk_vec("R1", {core_rst, force_zero, out_valid}, 3'b110);
    seen = {core_rst, force_zero, out_valid};
    mon_on = 1'b1;
    repeat (20) @(negedge clk);
    chk_vec("R1", {core_rst, force_zero, out_valid}, 3'b110);

    // Full sequence, strobes every 2 clocks (also running during hold: R5)
    sup = 1'b1;
    rise_edge = cyc + 1;
    wait_phase(1);
    chk_int("R2", rel_cyc - rise_edge + 1, HOLD + SYNC);
    chk_vec("R3", {core_rst, force_zero, out_valid}, 3'b010);
    wait_phase(2);
    chk_vec("R4", {core_rst, force_zero, out_valid}, 3'b001);

    // R6: strobes keep coming while live
    repeat (300) @(negedge clk);
    chk_vec("R6", {core_rst, force_zero, out_valid}, 3'b001);
    chk_int("R8", int'(out_valid != force_zero), 1);

    // R7: drop while live
    sup = 1'b0;
    wait_phase(0);
    chk_vec("R7", {core_rst, force_zero, out_valid}, 3'b110);

    // R7: drop during hold, then the full hold is needed again
    sup = 1'b1;
    repeat (600) @(negedge clk);
    chk_vec("R2", {core_rst, force_zero, out_valid}, 3'b110);
    sup = 1'b0;
    repeat (10) @(negedge clk);
    sup = 1'b1;
    rise_edge = cyc + 1;
    wait_phase(1);
    chk_int("R7", rel_cyc - rise_edge + 1, HOLD + SYNC);

    // R7: drop during settle, strobes now every 3 clocks
    stb_div = 3;
    do @(negedge clk); while (sc < 1000);
    sup = 1'b0;
    wait_phase(0);
    chk_vec("R7", {core_rst, force_zero, out_valid}, 3'b110);

    sup = 1'b1;
    rise_edge = cyc + 1;
    wait_phase(1);
    chk_int("R2", rel_cyc - rise_edge + 1, HOLD + SYNC);
    repeat (2000) @(negedge clk);
    // R5: pause strobes mid-settle, nothing must move
    stb_en = 1'b0;
    repeat (500) @(negedge clk);
    chk_vec("R5", {core_rst, force_zero, out_valid}, 3'b010);
    stb_en = 1'b1;
    wait_phase(2);
    chk_vec("R4", {core_rst, force_zero, out_valid}, 3'b001);
    chk_int("R4", q.size(), 0);

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; errs++;
      $display("FAIL R4: watchdog expired at cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end
endmodule